// File: doc/BRIEF.md
# Multi-Channel Heartbeat Health Supervisor

This block sits between a set of supervised tasks or subsystems and a hardware watchdog. Each of N channels carries a heartbeat pulse and has its own timeout budget; a per-channel down-counter reloads on every heartbeat. If the counter runs out, that channel's failed bit is set and stays set. Periodic service requests from software are forwarded to the watchdog as a one-cycle refresh pulse only while the health picture allows it.

The supervisor has three stages. In HEALTHY every enabled channel is alive and each service request is forwarded. The first failure moves it to DEGRADED. There requests are still forwarded, but each request made while a failure is present counts toward a programmable escalation limit. When the limit is reached the supervisor enters WITHHOLD. From then on it never refreshes the watchdog, so the watchdog eventually resets the system. Software may clear failed bits while DEGRADED, and the supervisor becomes HEALTHY again once every enabled channel has sent a heartbeat after the clear.

Top module: `hb_supervisor`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `sup_state` is 0 (HEALTHY), `fail_map` is all zero and `wd_refresh` is low.
- R2: For an enabled channel with budget B that gets no heartbeat, the channel's `fail_map` bit rises on the B+1-th rising clock edge after its last reload. A reload is the last reset edge, a heartbeat edge or a clear edge. The bit is still low after the B-th edge.
- R3: A heartbeat sampled on the edge where the channel's counter has just reached zero reloads the counter and prevents the failure. Heartbeats spaced at most B+1 edges apart keep the channel alive.
- R4: A channel whose `ch_enable` bit is low never sets its `fail_map` bit, its heartbeats have no effect, and it does not block refreshes or a return to HEALTHY.
- R5: A `svc_req` sampled in HEALTHY with no enabled channel failed produces `wd_refresh` high for exactly the next cycle. Each such request gives its own pulse, and no pulse appears without a request.
- R6: Any failed enabled channel moves HEALTHY to DEGRADED (`sup_state` = 1) on the next edge. A request sampled in HEALTHY while a failure is already flagged gets no refresh and is not counted toward escalation. HEALTHY never goes straight to WITHHOLD.
- R7: In DEGRADED, requests made while a failure is present are counted. With limit L, the first L-1 of them are refreshed and the L-th gets no refresh and moves the state to WITHHOLD (`sup_state` = 2). An L of 0 acts as 1.
- R8: In WITHHOLD no refresh is produced, `fail_clear` has no effect, and only reset leaves the state.
- R9: `fail_clear` in HEALTHY or DEGRADED clears all failed bits and reloads the counters. DEGRADED returns to HEALTHY once no enabled channel is failed and every enabled channel has sent a heartbeat since the clear.
- R10: `fail_map` bit i belongs to channel i. A set bit stays set when heartbeats resume, until `fail_clear` (R9) or reset. `sup_state` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_pulse | input | N_CH | Heartbeat per channel, bit i for channel i |
| ch_enable | input | N_CH | Channel enable, bit i for channel i |
| ch_budget | input | N_CH*CNT_W | Timeout budget per channel, channel i in bits [i*CNT_W +: CNT_W] |
| esc_limit | input | ESC_W | Number of failing requests in DEGRADED that triggers WITHHOLD |
| fail_clear | input | 1 | Software clear of failed bits |
| svc_req | input | 1 | Periodic service request |
| wd_refresh | output | 1 | One-cycle refresh pulse to the hardware watchdog |
| fail_map | output | N_CH | Sticky failed bit per channel |
| sup_state | output | 2 | 0 HEALTHY, 1 DEGRADED, 2 WITHHOLD |

## Verification
Two events can land on the same clock edge, and each case has a defined outcome. The first is a channel expiring while its heartbeat arrives. The bench releases reset, counts exactly B edges and raises the heartbeat on the next one; the failed bit must stay low there and rise exactly B+1 edges after that reload. The second is a service request sampled in the cycle when a new failure is already flagged but the state is still HEALTHY. The bench issues the request on the first cycle in which the failed bit is visible; the scoreboard expects no refresh pulse, and the state must move to DEGRADED with a full escalation count still remaining.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

    typedef enum logic [1:0] {
        SUP_HEALTHY  = 2'd0,
        SUP_DEGRADED = 2'd1,
        SUP_WITHHOLD = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic failed;
        logic reported;
    } ch_stat_t;

    // true when every enabled channel has reported since the last clear
    function automatic logic all_seen(input logic [63:0] en, input logic [63:0] rep, input int n);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (en[i] && !rep[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/hb_channel.sv
module hb_channel
    import hb_sup_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hb,
    input  logic             clr,
    input  logic [CNT_W-1:0] budget,
    output ch_stat_t         stat
);
    logic [CNT_W-1:0] left_q;
    logic             fail_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= budget;
            fail_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (clr) begin
            left_q <= budget;
            fail_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (!en) begin
            left_q <= budget;
        end else if (hb) begin
            left_q <= budget;
            seen_q <= 1'b1;
        end else if (left_q == '0) begin
            fail_q <= 1'b1;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        stat.failed   = fail_q;
        stat.reported = seen_q;
    end
endmodule

// File: rtl/hb_escalate.sv
module hb_escalate
    import hb_sup_pkg::*;
#(
    parameter int ESC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             svc_req,
    input  logic             any_fail,
    input  logic             all_rep,
    input  logic [ESC_W-1:0] limit,
    output sup_state_e       state,
    output logic             accept
);
    localparam int CW = ESC_W + 1;

    sup_state_e       state_q, state_d;
    logic [ESC_W-1:0] cnt_q, cnt_d;
    logic             escalate;
    logic [CW-1:0]    next_cnt;

    always_comb begin
        next_cnt = {1'b0, cnt_q} + 1'b1;
        escalate = (state_q == SUP_DEGRADED) && svc_req && any_fail &&
                   (next_cnt >= {1'b0, limit});
        accept   = svc_req &&
                   (((state_q == SUP_HEALTHY) && !any_fail) ||
                    ((state_q == SUP_DEGRADED) && !escalate));
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SUP_HEALTHY: begin
                cnt_d = '0;
                if (any_fail) state_d = SUP_DEGRADED;
            end
            SUP_DEGRADED: begin
                if (escalate) begin
                    state_d = SUP_WITHHOLD;
                end else if (svc_req && any_fail) begin
                    cnt_d = next_cnt[ESC_W-1:0];
                end else if (!any_fail && all_rep) begin
                    state_d = SUP_HEALTHY;
                    cnt_d   = '0;
                end
            end
            SUP_WITHHOLD: state_d = SUP_WITHHOLD;
            default:      state_d = SUP_WITHHOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SUP_HEALTHY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/hb_refresh_out.sv
module hb_refresh_out (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= accept;
    end
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
    import hb_sup_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    parameter int ESC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_CH-1:0]       hb_pulse,
    input  logic [N_CH-1:0]       ch_enable,
    input  logic [N_CH*CNT_W-1:0] ch_budget,
    input  logic [ESC_W-1:0]      esc_limit,
    input  logic                  fail_clear,
    input  logic                  svc_req,
    output logic                  wd_refresh,
    output logic [N_CH-1:0]       fail_map,
    output logic [1:0]            sup_state
);
    ch_stat_t   stat [N_CH];
    logic [N_CH-1:0] failed_v, seen_v;
    logic       any_fail, all_rep, clr, accept;
    sup_state_e state;

    assign clr = fail_clear && (state != SUP_WITHHOLD);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        hb_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (ch_enable[i]),
            .hb     (hb_pulse[i]),
            .clr    (clr),
            .budget (ch_budget[i*CNT_W +: CNT_W]),
            .stat   (stat[i])
        );
        assign failed_v[i] = stat[i].failed;
        assign seen_v[i]   = stat[i].reported;
    end

    always_comb begin
        logic [63:0] en_w, rep_w;
        en_w  = '0;
        rep_w = '0;
        en_w[N_CH-1:0]  = ch_enable;
        rep_w[N_CH-1:0] = seen_v;
        any_fail = |(failed_v & ch_enable);
        all_rep  = all_seen(en_w, rep_w, N_CH);
    end

    hb_escalate #(.ESC_W(ESC_W)) u_esc (
        .clk      (clk),
        .rst      (rst),
        .svc_req  (svc_req),
        .any_fail (any_fail),
        .all_rep  (all_rep),
        .limit    (esc_limit),
        .state    (state),
        .accept   (accept)
    );

    hb_refresh_out u_out (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .pulse  (wd_refresh)
    );

    assign fail_map  = failed_v;
    assign sup_state = state;
endmodule

// File: rtl/hb_supervisor_chk.sv
module hb_supervisor_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            svc_req,
    input logic            fail_clear,
    input logic            wd_refresh,
    input logic [N_CH-1:0] fail_map,
    input logic [1:0]      sup_state
);
    a_r5_refresh_needs_req: assert property (@(posedge clk) disable iff (rst)
        wd_refresh |-> $past(svc_req));

    a_r8_silent_in_withhold: assert property (@(posedge clk) disable iff (rst)
        (sup_state == 2'd2) |-> !wd_refresh);

    a_r8_withhold_sticks: assert property (@(posedge clk) disable iff (rst)
        (sup_state == 2'd2) |=> (sup_state == 2'd2));

    a_r6_no_direct_withhold: assert property (@(posedge clk) disable iff (rst)
        (sup_state == 2'd0) |=> (sup_state != 2'd2));

    a_r10_state_legal: assert property (@(posedge clk) disable iff (rst)
        sup_state != 2'd3);

    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        !fail_clear |=> ((fail_map & $past(fail_map)) == $past(fail_map)));
endmodule

bind hb_supervisor hb_supervisor_chk #(.N_CH(N_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .svc_req    (svc_req),
    .fail_clear (fail_clear),
    .wd_refresh (wd_refresh),
    .fail_map   (fail_map),
    .sup_state  (sup_state)
);

// File: tb/sim_hb_supervisor.sv
`timescale 1ns/1ps
module sim_hb_supervisor;
    localparam int N_CH = 4, CNT_W = 16, ESC_W = 4;

    logic clk = 0, rst = 1;
    logic [N_CH-1:0] feed_hb = '0, man_hb = '0, feed_mask = '0;
    logic [N_CH-1:0] hb_pulse, ch_enable;
    logic [N_CH*CNT_W-1:0] ch_budget;
    logic [ESC_W-1:0] esc_limit;
    logic fail_clear = 0, svc_req = 0;
    logic wd_refresh;
    logic [N_CH-1:0] fail_map;
    logic [1:0] sup_state;

    int total = 0, bad = 0, cyc = 0, fcnt = 0;
    bit done = 0;

    typedef struct { int c; bit e; string tag; } exp_t;
    exp_t q[$];

    assign hb_pulse = feed_hb | man_hb;

    hb_supervisor #(.N_CH(N_CH), .CNT_W(CNT_W), .ESC_W(ESC_W)) u0 (
        .clk(clk), .rst(rst), .hb_pulse(hb_pulse), .ch_enable(ch_enable),
        .ch_budget(ch_budget), .esc_limit(esc_limit), .fail_clear(fail_clear),
        .svc_req(svc_req), .wd_refresh(wd_refresh), .fail_map(fail_map),
        .sup_state(sup_state));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // feeder: heartbeat on the masked channels every 8 cycles
    always @(negedge clk) begin
        fcnt <= fcnt + 1;
        feed_hb <= (fcnt % 8 == 0) ? feed_mask : '0;
    end

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: compares wd_refresh against the scoreboard queue
    always @(negedge clk) begin
        if (rst) q.delete();
        else if (q.size() != 0 && q[0].c == cyc) begin
            exp_t it;
            it = q.pop_front();
            chk(it.tag, int'(wd_refresh), int'(it.e));
        end else if (wd_refresh) begin
            chk("R5 unrequested refresh", 1, 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(input bit e, input string tag);
        exp_t it;
        it.c = cyc + 1; it.e = e; it.tag = tag;
        q.push_back(it);
        svc_req = 1;
        @(negedge clk);
        svc_req = 0;
    endtask

    task automatic do_reset;
        rst = 1; svc_req = 0; fail_clear = 0; man_hb = '0;
        tick(3);
        rst = 0;
    endtask

    task automatic finish_sim;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_sim();
        end
    end

    initial begin
        ch_enable = 4'b0111;
        ch_budget = {16'd5, 16'd30, 16'd20, 16'd10};
        esc_limit = 4'd3;

        // phase 1: healthy operation
        feed_mask = 4'b0111;
        @(negedge clk);
        do_reset();
        chk("R1 state", sup_state, 0);
        chk("R1 fail_map", fail_map, 0);
        chk("R1 refresh", wd_refresh, 0);
        tick(40);
        chk("R4 disabled ch3 never fails", fail_map, 0);
        req(1, "R5 refresh healthy");
        req(1, "R5 back-to-back refresh");
        tick(3);
        chk("R4 state healthy with ch3 silent", sup_state, 0);

        // phase 2: exact expiry, same-cycle collisions, escalation
        feed_mask = 4'b0110;
        do_reset();
        tick(10);
        chk("R2 ch0 alive after B edges", fail_map[0], 0);
        man_hb = 4'b0001;
        tick(1);
        man_hb = '0;
        chk("R3 heartbeat on expiry edge", fail_map[0], 0);
        tick(10);
        chk("R2 ch0 alive B edges after reload", fail_map[0], 0);
        tick(1);
        chk("R2 ch0 failed on edge B+1", fail_map[0], 1);
        chk("R6 still healthy before transition", sup_state, 0);
        req(0, "R6 request with failure flagged in HEALTHY");
        chk("R6 degraded", sup_state, 1);
        chk("R10 only ch0 flagged", fail_map, 4'b0001);
        feed_mask = 4'b0111;
        tick(20);
        chk("R10 failed bit sticky", fail_map[0], 1);
        req(1, "R7 degraded refresh 1");
        req(1, "R7 degraded refresh 2");
        req(0, "R7 limit request withheld");
        chk("R7 withhold state", sup_state, 2);
        req(0, "R8 no refresh in withhold");
        fail_clear = 1;
        tick(1);
        fail_clear = 0;
        tick(1);
        chk("R8 clear ignored", fail_map[0], 1);
        chk("R8 withhold held", sup_state, 2);

        // phase 3: recovery from DEGRADED
        esc_limit = 4'd15;
        do_reset();
        tick(20);
        chk("R9 healthy start", sup_state, 0);
        feed_mask = 4'b0110;
        tick(25);
        chk("R9 degraded after miss", sup_state, 1);
        fail_clear = 1;
        tick(1);
        fail_clear = 0;
        chk("R9 bits cleared", fail_map, 0);
        tick(3);
        chk("R9 stays degraded until all report", sup_state, 1);
        man_hb = 4'b0001;
        tick(1);
        man_hb = '0;
        feed_mask = 4'b0111;
        tick(12);
        chk("R9 back to healthy", sup_state, 0);
        chk("R9 no failure", fail_map, 0);
        req(1, "R5 refresh after recovery");
        tick(3);
        finish_sim();
    end
endmodule